// File: doc/BRIEF.md
# Post-Update Load/Store Address Unit

This unit carries out one load or store that also rewrites its base register, for a 64-bit integer core. A decoded operation arrives with its access size, its load or store kind, its signed or unsigned extension, its immediate or indexed form, and its update mode. It also brings the base operand (RA), the index operand (RB), the store source (RS) and the displacement field. The unit computes the access address and the new base value. It then issues a single memory request and waits for the memory response. Finally it hands back the loaded register value and the new base value, each with its own write enable.

Two update modes are supported. In pre-update mode the offset is added first, and the sum is both the access address and the new base. In post-update mode the access goes to the unmodified base value, and the offset only produces the base value written back afterwards. The unit changes no condition or status state. It accepts no new operation until the current one has finished.

Top module: `lspu_post_update`

## Requirements
- R1: In post-update mode (`op_post`=1) the request address `mem_addr` equals the `ra_val` presented with the accepted operation, with no offset added.
- R2: In post-update mode the written-back `ra_data` is `ra_val` plus the offset. The offset is `rb_val` in indexed form (`op_indexed`=1) and the sign-extended 16-bit `disp` in immediate form.
- R3: In pre-update mode (`op_post`=0) `mem_addr` and `ra_data` are both `ra_val` plus the offset.
- R4: For a doubleword (`op_size`=3) in immediate form, the offset is formed differently. The low 14 bits of `disp` get two zero bits appended and the 16-bit result is sign-extended. Bits 15:14 of `disp` have no effect.
- R5: Size encoding is 0=byte, 1=halfword, 2=word, 3=doubleword, and `mem_size` echoes it. Byte k of the 8-byte memory word is `mem_rsp_data[8k+7:8k]`, and the accessed lanes start at lane `mem_addr[2:0]`. An unsigned load (`op_signed`=0) puts those bytes in the low bits of `rt_data` and clears every upper bit.
- R6: A halfword or word load with `op_signed`=1 sign-extends to 64 bits. `op_signed` has no effect on byte loads (always zero-extended) or doubleword loads.
- R7: A store (`op_store`=1) drives `mem_we`=1 and sets `mem_be` to (2^bytes-1) shifted left by `mem_addr[2:0]`. It places the least significant 1, 2, 4 or 8 bytes of `rs_val` in the enabled lanes of `mem_wdata`. Loads drive `mem_we`=0.
- R8: `res_valid`, `ra_we` and `rt_data` are driven combinationally, in the same cycle that `mem_rsp_valid` is high. For a load, `rt_we` is also 1 in that cycle. For a store, `ra_we` is 1 and `rt_we` is 0. Outside that cycle all three strobes are 0.
- R9: Once raised, `mem_req_valid` stays high with a steady address until `mem_req_ready`. `op_ready` is 0 from acceptance until the response, and operations offered meanwhile are ignored.
- R10: After reset `op_ready`=1 and `mem_req_valid`=`res_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when valid |
| op_size | input | 2 | Access size: 0 byte, 1 half, 2 word, 3 double |
| op_signed | input | 1 | Sign-extend halfword/word loads |
| op_store | input | 1 | 1 store, 0 load |
| op_indexed | input | 1 | 1 offset from RB, 0 offset from displacement |
| op_post | input | 1 | 1 post-update, 0 pre-update |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| rs_val | input | 64 | Store source value |
| disp | input | 16 | Displacement field |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request taken |
| mem_addr | output | 64 | Access address |
| mem_size | output | 2 | Access size |
| mem_be | output | 8 | Byte lane enables |
| mem_we | output | 1 | Write request |
| mem_wdata | output | 64 | Lane-aligned store data |
| mem_rsp_valid | input | 1 | Memory response / write acknowledge |
| mem_rsp_data | input | 64 | 8-byte read word |
| res_valid | output | 1 | Results valid this cycle |
| rt_we | output | 1 | Write enable for loaded value |
| rt_data | output | 64 | Loaded, extended value |
| ra_we | output | 1 | Write enable for new base |
| ra_data | output | 64 | New base value |

## Verification
The request appears one cycle after the accepting edge. The bench samples address, enables and store data at the following falling edge, and during any stall cycles it inserts. Results are combinational from the response, so the bench raises `mem_rsp_valid` at a falling edge and samples `res_valid`, the write enables and both data values a step later, within that same cycle. One cycle after the response edge, it checks that the unit is idle and no request is pending. The sweep covers every combination of size, signedness, direction, form and mode, with aligned random bases and offsets.

// File: rtl/lspu_pkg.sv
package lspu_pkg;
   typedef enum logic [1:0] {
      SZ_B = 2'd0,
      SZ_H = 2'd1,
      SZ_W = 2'd2,
      SZ_D = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_REQ  = 2'd1,
      PH_WAIT = 2'd2
   } phase_e;
endpackage

// File: rtl/lspu_addr_gen.sv
module lspu_addr_gen
   import lspu_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int DISP_W   = 16,
   parameter int DS_SHIFT = 2
) (
   input  logic [XLEN-1:0]   ra,
   input  logic [XLEN-1:0]   rb,
   input  logic [DISP_W-1:0] disp,
   input  acc_size_e         size,
   input  logic              indexed,
   input  logic              post,
   output logic [XLEN-1:0]   addr,
   output logic [XLEN-1:0]   new_base
);
   logic [DISP_W-1:0] dsp;
   logic [XLEN-1:0]   imm_off;
   logic [XLEN-1:0]   off;
   logic [XLEN-1:0]   sum;

   always_comb begin
      // doubleword immediate: scaled field
      if (size == SZ_D)
         dsp = {disp[DISP_W-1-DS_SHIFT:0], {DS_SHIFT{1'b0}}};
      else
         dsp = disp;
      imm_off  = {{(XLEN-DISP_W){dsp[DISP_W-1]}}, dsp};
      off      = indexed ? rb : imm_off;
      sum      = ra + off;
      addr     = post ? ra : sum;
      new_base = sum;
   end
endmodule

// File: rtl/lspu_lane_pack.sv
module lspu_lane_pack
   import lspu_pkg::*;
#(
   parameter int XLEN  = 64,
   localparam int LANES = XLEN / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  acc_size_e        size,
   input  logic [OFS_W-1:0] ofs,
   input  logic [XLEN-1:0]  rs,
   output logic [LANES-1:0] be,
   output logic [XLEN-1:0]  wdata
);
   localparam int CW = OFS_W + 2;

   logic [CW-1:0] lo_w;
   logic [CW-1:0] hi_w;

   assign lo_w  = CW'(ofs);
   assign hi_w  = lo_w + (CW'(1) << size);
   assign wdata = rs << {ofs, 3'b000};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be[i] = (CW'(i) >= lo_w) && (CW'(i) < hi_w);
   end
endmodule

// File: rtl/lspu_load_align.sv
module lspu_load_align
   import lspu_pkg::*;
#(
   parameter int XLEN  = 64,
   localparam int LANES = XLEN / 8,
   localparam int OFS_W = $clog2(LANES)
) (
   input  logic [XLEN-1:0]  rdata,
   input  logic [OFS_W-1:0] ofs,
   input  acc_size_e        size,
   input  logic             sgn,
   output logic [XLEN-1:0]  rt
);
   logic [XLEN-1:0] sh;

   always_comb begin
      sh = rdata >> {ofs, 3'b000};
      unique case (size)
         SZ_B:    rt = {{(XLEN-8){1'b0}}, sh[7:0]};
         SZ_H:    rt = {{(XLEN-16){sgn & sh[15]}}, sh[15:0]};
         SZ_W:    rt = {{(XLEN-32){sgn & sh[31]}}, sh[31:0]};
         default: rt = sh;
      endcase
   end
endmodule

// File: rtl/lspu_post_update.sv
module lspu_post_update
   import lspu_pkg::*;
#(
   parameter int XLEN     = 64,
   parameter int DISP_W   = 16,
   parameter int DS_SHIFT = 2,
   localparam int LANES   = XLEN / 8,
   localparam int OFS_W   = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   output logic              op_ready,
   input  logic [1:0]        op_size,
   input  logic              op_signed,
   input  logic              op_store,
   input  logic              op_indexed,
   input  logic              op_post,
   input  logic [XLEN-1:0]   ra_val,
   input  logic [XLEN-1:0]   rb_val,
   input  logic [XLEN-1:0]   rs_val,
   input  logic [DISP_W-1:0] disp,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [XLEN-1:0]   mem_addr,
   output logic [1:0]        mem_size,
   output logic [LANES-1:0]  mem_be,
   output logic              mem_we,
   output logic [XLEN-1:0]   mem_wdata,
   input  logic              mem_rsp_valid,
   input  logic [XLEN-1:0]   mem_rsp_data,
   output logic              res_valid,
   output logic              rt_we,
   output logic [XLEN-1:0]   rt_data,
   output logic              ra_we,
   output logic [XLEN-1:0]   ra_data
);
   if ((XLEN % 8) != 0 || LANES < 8 || (LANES & (LANES - 1)) != 0) begin : g_bad_xlen
      $error("lspu_post_update: XLEN must be a power-of-two byte count of at least 64 bits");
   end
   if (DISP_W <= DS_SHIFT || DISP_W > XLEN) begin : g_bad_disp
      $error("lspu_post_update: DISP_W out of range");
   end

   phase_e          phase;
   acc_size_e       size_q;
   logic            store_q;
   logic            sgn_q;
   logic [XLEN-1:0] addr_q;
   logic [XLEN-1:0] base_q;
   logic [XLEN-1:0] rs_q;
   logic [XLEN-1:0] addr_c;
   logic [XLEN-1:0] base_c;
   logic            accept;

   assign accept = op_valid && (phase == PH_IDLE);

   lspu_addr_gen #(
      .XLEN(XLEN), .DISP_W(DISP_W), .DS_SHIFT(DS_SHIFT)
   ) u_agen (
      .ra       (ra_val),
      .rb       (rb_val),
      .disp     (disp),
      .size     (acc_size_e'(op_size)),
      .indexed  (op_indexed),
      .post     (op_post),
      .addr     (addr_c),
      .new_base (base_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         size_q  <= SZ_B;
         store_q <= 1'b0;
         sgn_q   <= 1'b0;
         addr_q  <= '0;
         base_q  <= '0;
         rs_q    <= '0;
      end else begin
         unique case (phase)
            PH_IDLE: if (accept) begin
               phase   <= PH_REQ;
               size_q  <= acc_size_e'(op_size);
               store_q <= op_store;
               sgn_q   <= op_signed;
               addr_q  <= addr_c;
               base_q  <= base_c;
               rs_q    <= rs_val;
            end
            PH_REQ:  if (mem_req_ready) phase <= PH_WAIT;
            PH_WAIT: if (mem_rsp_valid) phase <= PH_IDLE;
            default: phase <= PH_IDLE;
         endcase
      end
   end

   lspu_lane_pack #(.XLEN(XLEN)) u_pack (
      .size  (size_q),
      .ofs   (addr_q[OFS_W-1:0]),
      .rs    (rs_q),
      .be    (mem_be),
      .wdata (mem_wdata)
   );

   lspu_load_align #(.XLEN(XLEN)) u_align (
      .rdata (mem_rsp_data),
      .ofs   (addr_q[OFS_W-1:0]),
      .size  (size_q),
      .sgn   (sgn_q),
      .rt    (rt_data)
   );

   assign op_ready      = (phase == PH_IDLE);
   assign mem_req_valid = (phase == PH_REQ);
   assign mem_addr      = addr_q;
   assign mem_size      = size_q;
   assign mem_we        = store_q;
   assign res_valid     = (phase == PH_WAIT) && mem_rsp_valid;
   assign rt_we         = res_valid && !store_q;
   assign ra_we         = res_valid;
   assign ra_data       = base_q;
endmodule

// File: rtl/lspu_post_update_chk.sv
module lspu_post_update_chk #(
   parameter int XLEN  = 64,
   parameter int LANES = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic             op_ready,
   input logic             op_post,
   input logic             op_store,
   input logic [XLEN-1:0]  ra_val,
   input logic             mem_req_valid,
   input logic             mem_req_ready,
   input logic [XLEN-1:0]  mem_addr,
   input logic [1:0]       mem_size,
   input logic [LANES-1:0] mem_be,
   input logic             res_valid,
   input logic             rt_we,
   input logic             ra_we,
   input logic [XLEN-1:0]  ra_data
);
   logic chk_pre;
   logic chk_store;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chk_pre   <= 1'b0;
         chk_store <= 1'b0;
      end else if (op_valid && op_ready) begin
         chk_pre   <= !op_post;
         chk_store <= op_store;
      end
   end

   assert_post_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && op_post) |=> (mem_addr == $past(ra_val)));

   assert_pre_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && chk_pre) |-> (ra_data == mem_addr));

   assert_be_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> ($countones(mem_be) == (32'd1 << mem_size)));

   assert_wb_enables_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (ra_we && (rt_we == !chk_store)));

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_addr)));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !op_ready);
endmodule

bind lspu_post_update lspu_post_update_chk #(.XLEN(XLEN), .LANES(LANES)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_valid      (op_valid),
   .op_ready      (op_ready),
   .op_post       (op_post),
   .op_store      (op_store),
   .ra_val        (ra_val),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_addr      (mem_addr),
   .mem_size      (mem_size),
   .mem_be        (mem_be),
   .res_valid     (res_valid),
   .rt_we         (rt_we),
   .ra_we         (ra_we),
   .ra_data       (ra_data)
);

// File: tb/lspu_post_update_test.sv
module lspu_post_update_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic        op_ready;
   logic [1:0]  op_size = 2'd0;
   logic        op_signed = 1'b0;
   logic        op_store = 1'b0;
   logic        op_indexed = 1'b0;
   logic        op_post = 1'b0;
   logic [63:0] ra_val = '0;
   logic [63:0] rb_val = '0;
   logic [63:0] rs_val = '0;
   logic [15:0] disp = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [63:0] mem_addr;
   logic [1:0]  mem_size;
   logic [7:0]  mem_be;
   logic        mem_we;
   logic [63:0] mem_wdata;
   logic        mem_rsp_valid = 1'b0;
   logic [63:0] mem_rsp_data = '0;
   logic        res_valid;
   logic        rt_we;
   logic [63:0] rt_data;
   logic        ra_we;
   logic [63:0] ra_data;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [63:0] seed = 64'h9E3779B97F4A7C15;

   always #4 clk = ~clk;

   lspu_post_update uut (.*);

   function automatic logic [63:0] next_rand();
      seed = seed ^ (seed << 13);
      seed = seed ^ (seed >> 7);
      seed = seed ^ (seed << 17);
      return seed;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(input logic [1:0] sz, input logic sg, input logic st,
                         input logic ix, input logic po, input logic [63:0] ra,
                         input logic [63:0] rb, input logic [63:0] rs,
                         input logic [15:0] dp, input logic [63:0] rdata,
                         input int stall);
      logic [63:0] off, sum, ea, bmask, lane, ert;
      logic [15:0] dsp;
      logic [7:0]  ebe;
      int nb;
      nb  = 1 << sz;
      dsp = (sz == 2'd3 && !ix) ? {dp[13:0], 2'b00} : dp;
      off = ix ? rb : {{48{dsp[15]}}, dsp};
      sum = ra + off;
      ea  = po ? ra : sum;
      ebe = 8'(((16'd1 << nb) - 16'd1) << ea[2:0]);
      bmask = '0;
      for (int k = 0; k < 8; k++) if (ebe[k]) bmask[8*k +: 8] = 8'hFF;
      lane = rdata >> (ea[2:0] * 8);
      case (sz)
         2'd0: ert = {56'd0, lane[7:0]};
         2'd1: ert = {{48{sg & lane[15]}}, lane[15:0]};
         2'd2: ert = {{32{sg & lane[31]}}, lane[31:0]};
         default: ert = lane;
      endcase

      @(negedge clk);
      op_valid = 1'b1; op_size = sz; op_signed = sg; op_store = st;
      op_indexed = ix; op_post = po; ra_val = ra; rb_val = rb; rs_val = rs; disp = dp;
      @(negedge clk);
      // a second operation offered while busy must be ignored (R9)
      ra_val = ~ra; rb_val = ~rb; op_post = ~po; op_size = ~sz;
      for (int s = 0; s < stall; s++) begin
         #1;
         check("R9 req held", {63'd0, mem_req_valid}, 64'd1);
         check("R9 op_ready low", {63'd0, op_ready}, 64'd0);
         @(negedge clk);
      end
      #1;
      check("R9 req valid", {63'd0, mem_req_valid}, 64'd1);
      check(po ? "R1 post addr" : "R3 pre addr", mem_addr, ea);
      check("R5 mem_size", {62'd0, mem_size}, {62'd0, sz});
      check("R7 mem_we", {63'd0, mem_we}, {63'd0, st});
      if (st) begin
         check("R7 byte enables", {56'd0, mem_be}, {56'd0, ebe});
         check("R7 store data", mem_wdata & bmask, (rs << (ea[2:0] * 8)) & bmask);
      end
      mem_req_ready = 1'b1;
      op_valid = 1'b0;
      @(negedge clk);
      mem_req_ready = 1'b0;
      #1;
      check("R8 no result before response", {63'd0, res_valid}, 64'd0);
      mem_rsp_valid = 1'b1;
      mem_rsp_data = rdata;
      #1;
      check("R8 res_valid", {63'd0, res_valid}, 64'd1);
      check("R8 ra_we", {63'd0, ra_we}, 64'd1);
      check("R8 rt_we", {63'd0, rt_we}, {63'd0, !st});
      check(po ? "R2 post new base" : "R3 pre new base", ra_data, sum);
      if (!st) check((sz == 2'd1 || sz == 2'd2) && sg ? "R6 signed load" : "R5 zero load", rt_data, ert);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      check("R9 idle after response", {62'd0, op_ready, mem_req_valid}, 64'd2);
      check("R8 strobe low after", {63'd0, res_valid}, 64'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      total++;
      bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R10 op_ready after reset", {63'd0, op_ready}, 64'd1);
      check("R10 no request after reset", {63'd0, mem_req_valid}, 64'd0);
      check("R10 no result after reset", {63'd0, res_valid}, 64'd0);

      // R4: scaled doubleword displacement, upper field bits ignored
      run_op(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 64'h1000, 64'h0, 64'h0, 16'h3FFE,
             64'h0123456789ABCDEF, 0);
      run_op(2'd3, 1'b0, 1'b1, 1'b0, 1'b0, 64'h1000, 64'h0, 64'h55AA, 16'hBFFE,
             64'h0, 0);
      check("R4 upper disp bits ignored", ra_data, 64'h0FF8);
      run_op(2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 64'h2000, 64'h0, 64'h0, 16'h0002,
             64'hFFFF0000FFFF0000, 1);
      check("R4 post scaled base", ra_data, 64'h2008);

      // R6: signed byte load still zero-extends
      run_op(2'd0, 1'b1, 1'b0, 1'b0, 1'b1, 64'h3007, 64'h0, 64'h0, 16'h0008,
             64'h80FFFFFFFFFFFFFF, 0);
      check("R6 signed byte zero-extended", rt_data, 64'h80);

      for (int rep = 0; rep < 4; rep++) begin
         for (int code = 0; code < 64; code++) begin
            logic [1:0]  sz;
            logic [63:0] ra, rb, rs, rd;
            logic [15:0] dp;
            sz = code[1:0];
            ra = next_rand() & ~((64'd1 << sz) - 64'd1);
            rb = next_rand() & ~64'd7;
            rs = next_rand();
            rd = next_rand();
            dp = 16'(next_rand()) & ~16'd7;
            run_op(sz, code[2], code[3], code[4], code[5], ra, rb, rs, dp, rd,
                   (code % 3 == 0) ? rep : 0);
         end
      end
      finish_run();
   end
endmodule